// File: doc/BRIEF.md
# Accumulator ALU with Status Register

This block is the arithmetic and logic core of a small accumulator CPU. Each cycle it can accept one operation. The operation takes a register value (the accumulator or an index register, chosen by the caller) and an operand byte. The block combines them under a 5-bit operation code. On the same clock edge it writes the result into a result register and the new flags into the status register it owns. The carry used by add, subtract and rotate is always the carry bit already held in that status register.

The status byte keeps four live flags: sign at bit 7, overflow at bit 6, zero at bit 1 and carry at bit 0. Add, subtract and compare rebuild the whole byte, so every other bit ends as zero. Logic, increment, decrement and move touch only zero and sign. Shifts and rotates touch zero, sign and carry. Bit-test touches sign, overflow and zero. Four requests act on the status byte alone: set carry, clear carry, clear overflow and load the whole byte.

The datapath width is a parameter with a default of 8 and a minimum of 8. A second parameter chooses between an explicit ripple-carry adder and an adder written as plain arithmetic.

Top module: `alu8_flagcore`

## Requirements
- R1: While rst_n is low, and on leaving reset, status_q, result_q and res_vld_q are all zero.
- R2: Code 0x00 (add) writes reg + opnd + C, taken modulo 256, to result_q. It sets C when the 9-bit sum is 256 or more, and sets V when reg and opnd share a sign bit and the result's sign differs. N and Z follow the result, and status bits 5..2 become 0.
- R3: Code 0x01 (subtract) behaves as add with opnd inverted bitwise: reg + (opnd XOR 0xFF) + C. C=1 means no borrow. Flags are formed as in R2, and status bits 5..2 become 0.
- R4: Code 0x02 (compare) sets N, V, Z and C from reg + (opnd XOR 0xFF) + 1 and clears status bits 5..2. result_q is left unchanged.
- R5: Codes 0x03 (AND), 0x04 (OR), 0x05 (XOR) and 0x0D (move, result = opnd) write their result. They update only N and Z; status bits 6 and 5..2 and C keep their values.
- R6: Codes 0x0A (increment reg) and 0x0B (decrement reg) wrap modulo 256 (0xFF+1 = 0x00, 0x00-1 = 0xFF) and update only N and Z.
- R7: Code 0x06 (shift left reg) shifts in 0 and code 0x08 (rotate left reg) shifts in the old C at bit 0. Both put the old bit 7 into C, update N and Z, and keep V and bits 5..2.
- R8: Code 0x07 (shift right reg) shifts in 0 and code 0x09 (rotate right reg) shifts in the old C at bit 7. Both put the old bit 0 into C, update N and Z, and keep V and bits 5..2.
- R9: Code 0x0C (bit-test) copies opnd bit 7 to N and opnd bit 6 to V, and sets Z when (reg AND opnd) is 0. It keeps C and bits 5..2 and leaves result_q unchanged.
- R10: Code 0x10 sets C, 0x11 clears C, 0x12 clears V, and 0x13 loads the whole status byte from opnd. Each changes nothing else and leaves result_q unchanged.
- R11: With op_valid low, or with any code not listed above, status_q and result_q keep their values.
- R12: res_vld_q is 1 for exactly the cycle that follows an accepted result-writing operation (codes 0x00, 0x01, 0x03 to 0x0B and 0x0D), and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| reg_i | input | WIDTH | Accumulator or index value |
| opnd_i | input | WIDTH | Operand value |
| result_q | output | WIDTH | Last written result |
| status_q | output | 8 | Status byte: N bit 7, V bit 6, Z bit 1, C bit 0 |
| res_vld_q | output | 1 | result_q was written on the last edge |

## Verification
The properties assume that op_valid, op_code and both data inputs are stable and known around each rising edge, since every check compares a registered output with the inputs seen one cycle earlier. They also assume the default width, because the flag bit positions are checked as fixed byte positions. The stimulus changes inputs only on falling edges. It covers every one of the 32 codes, including the unassigned ones, under random data, and holds op_valid low for about a fifth of the cycles. A directed opening sequence first preloads the status byte with all ones, so that the clearing done by the arithmetic operations and the bits kept by the other operations can be seen.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   localparam int SR_W  = 8;
   localparam int N_BIT = 7;
   localparam int V_BIT = 6;
   localparam int Z_BIT = 1;
   localparam int C_BIT = 0;

   typedef enum logic [4:0] {
      OP_ADD_C = 5'h00,
      OP_SUB_B = 5'h01,
      OP_CMP   = 5'h02,
      OP_AND   = 5'h03,
      OP_OR    = 5'h04,
      OP_XOR   = 5'h05,
      OP_SHL   = 5'h06,
      OP_SHR   = 5'h07,
      OP_RTL   = 5'h08,
      OP_RTR   = 5'h09,
      OP_INC   = 5'h0A,
      OP_DEC   = 5'h0B,
      OP_TEST  = 5'h0C,
      OP_MOVE  = 5'h0D,
      OP_SETC  = 5'h10,
      OP_CLRC  = 5'h11,
      OP_CLRV  = 5'h12,
      OP_LDST  = 5'h13
   } alu_op_e;

   function automatic logic op_writes_result(logic [4:0] code);
      case (code)
         5'h00, 5'h01, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07,
         5'h08, 5'h09, 5'h0A, 5'h0B, 5'h0D: return 1'b1;
         default:                           return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic             cin_i,
   output logic [WIDTH-1:0] sum_o,
   output logic             cout_o,
   output logic             ovf_o
);

   generate
      if (RIPPLE) begin : g_ripple
         logic [WIDTH:0] cy;
         assign cy[0] = cin_i;
         for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign sum_o[i]  = a_i[i] ^ b_i[i] ^ cy[i];
            assign cy[i+1]   = (a_i[i] & b_i[i]) | (cy[i] & (a_i[i] ^ b_i[i]));
         end
         assign cout_o = cy[WIDTH];
         // signed overflow: carry into the top bit differs from carry out
         assign ovf_o  = cy[WIDTH] ^ cy[WIDTH-1];
      end else begin : g_behav
         logic [WIDTH:0] wide;
         assign wide   = {1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i};
         assign sum_o  = wide[WIDTH-1:0];
         assign cout_o = wide[WIDTH];
         assign ovf_o  = (a_i[WIDTH-1] == b_i[WIDTH-1]) && (wide[WIDTH-1] != a_i[WIDTH-1]);
      end
   endgenerate

endmodule

// File: rtl/alu8_arith.sv
module alu8_arith
   import alu8_pkg::*;
#(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b0
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] reg_i,
   input  logic [WIDTH-1:0] opnd_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] res_o,
   output logic             carry_o,
   output logic             ovf_o
);

   logic [WIDTH-1:0] b_eff;
   logic             cin_eff;

   // subtract and compare both add the inverted operand
   always_comb begin
      b_eff   = (op_i == OP_ADD_C) ? opnd_i : ~opnd_i;
      cin_eff = (op_i == OP_CMP) ? 1'b1 : carry_i;
   end

   alu8_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .a_i    (reg_i),
      .b_i    (b_eff),
      .cin_i  (cin_eff),
      .sum_o  (res_o),
      .cout_o (carry_o),
      .ovf_o  (ovf_o)
   );

endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] reg_i,
   input  logic [WIDTH-1:0] opnd_i,
   output logic [WIDTH-1:0] res_o,
   output logic             test_zero_o
);

   logic [WIDTH-1:0] masked;

   always_comb begin
      masked      = reg_i & opnd_i;
      test_zero_o = (masked == '0);
      case (op_i)
         OP_AND:  res_o = masked;
         OP_OR:   res_o = reg_i | opnd_i;
         OP_XOR:  res_o = reg_i ^ opnd_i;
         default: res_o = opnd_i;
      endcase
   end

endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  alu_op_e          op_i,
   input  logic [WIDTH-1:0] val_i,
   input  logic             carry_i,
   output logic [WIDTH-1:0] res_o,
   output logic             carry_o
);

   logic             fill_lo;
   logic             fill_hi;
   logic [WIDTH-1:0] left_v;
   logic [WIDTH-1:0] right_v;

   assign fill_lo = (op_i == OP_RTL) ? carry_i : 1'b0;
   assign fill_hi = (op_i == OP_RTR) ? carry_i : 1'b0;

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_lane
         if (i == 0) begin : g_lo
            assign left_v[i]  = fill_lo;
            assign right_v[i] = val_i[i+1];
         end else if (i == WIDTH-1) begin : g_hi
            assign left_v[i]  = val_i[i-1];
            assign right_v[i] = fill_hi;
         end else begin : g_mid
            assign left_v[i]  = val_i[i-1];
            assign right_v[i] = val_i[i+1];
         end
      end
   endgenerate

   always_comb begin
      carry_o = 1'b0;
      case (op_i)
         OP_SHL, OP_RTL: begin
            res_o   = left_v;
            carry_o = val_i[WIDTH-1];
         end
         OP_SHR, OP_RTR: begin
            res_o   = right_v;
            carry_o = val_i[0];
         end
         OP_INC:  res_o = val_i + 1'b1;
         default: res_o = val_i - 1'b1;
      endcase
   end

endmodule

// File: rtl/alu8_flagcore.sv
module alu8_flagcore
   import alu8_pkg::*;
#(
   parameter int WIDTH      = 8,
   parameter bit RIPPLE_ADD = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 op_valid,
   input  logic [4:0]           op_code,
   input  logic [WIDTH-1:0]     reg_i,
   input  logic [WIDTH-1:0]     opnd_i,
   output logic [WIDTH-1:0]     result_q,
   output logic [SR_W-1:0]      status_q,
   output logic                 res_vld_q
);

   localparam int MSB = WIDTH - 1;

   generate
      if (WIDTH < SR_W) begin : g_width_chk
         $error("alu8_flagcore: WIDTH must be at least 8");
      end
   endgenerate

   alu_op_e          op;
   logic [WIDTH-1:0] ar_res;
   logic             ar_c;
   logic             ar_v;
   logic [WIDTH-1:0] lg_res;
   logic             lg_tz;
   logic [WIDTH-1:0] un_res;
   logic             un_c;
   logic [SR_W-1:0]  st_n;
   logic [WIDTH-1:0] res_n;
   logic             wr_n;

   assign op = alu_op_e'(op_code);

   alu8_arith #(.WIDTH(WIDTH), .RIPPLE(RIPPLE_ADD)) u_arith (
      .op_i    (op),
      .reg_i   (reg_i),
      .opnd_i  (opnd_i),
      .carry_i (status_q[C_BIT]),
      .res_o   (ar_res),
      .carry_o (ar_c),
      .ovf_o   (ar_v)
   );

   alu8_logic #(.WIDTH(WIDTH)) u_logic (
      .op_i        (op),
      .reg_i       (reg_i),
      .opnd_i      (opnd_i),
      .res_o       (lg_res),
      .test_zero_o (lg_tz)
   );

   alu8_unary #(.WIDTH(WIDTH)) u_unary (
      .op_i    (op),
      .val_i   (reg_i),
      .carry_i (status_q[C_BIT]),
      .res_o   (un_res),
      .carry_o (un_c)
   );

   always_comb begin
      st_n  = status_q;
      res_n = result_q;
      wr_n  = 1'b0;
      if (op_valid) begin
         case (op)
            OP_ADD_C, OP_SUB_B, OP_CMP: begin
               st_n        = '0;
               st_n[N_BIT] = ar_res[MSB];
               st_n[V_BIT] = ar_v;
               st_n[Z_BIT] = (ar_res == '0);
               st_n[C_BIT] = ar_c;
               if (op != OP_CMP) begin
                  res_n = ar_res;
                  wr_n  = 1'b1;
               end
            end
            OP_AND, OP_OR, OP_XOR, OP_MOVE: begin
               st_n[N_BIT] = lg_res[MSB];
               st_n[Z_BIT] = (lg_res == '0);
               res_n       = lg_res;
               wr_n        = 1'b1;
            end
            OP_SHL, OP_SHR, OP_RTL, OP_RTR: begin
               st_n[N_BIT] = un_res[MSB];
               st_n[Z_BIT] = (un_res == '0);
               st_n[C_BIT] = un_c;
               res_n       = un_res;
               wr_n        = 1'b1;
            end
            OP_INC, OP_DEC: begin
               st_n[N_BIT] = un_res[MSB];
               st_n[Z_BIT] = (un_res == '0);
               res_n       = un_res;
               wr_n        = 1'b1;
            end
            OP_TEST: begin
               st_n[N_BIT] = opnd_i[MSB];
               st_n[V_BIT] = opnd_i[MSB-1];
               st_n[Z_BIT] = lg_tz;
            end
            OP_SETC: st_n[C_BIT] = 1'b1;
            OP_CLRC: st_n[C_BIT] = 1'b0;
            OP_CLRV: st_n[V_BIT] = 1'b0;
            OP_LDST: st_n = opnd_i[SR_W-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q  <= '0;
         result_q  <= '0;
         res_vld_q <= 1'b0;
      end else begin
         status_q  <= st_n;
         result_q  <= res_n;
         res_vld_q <= wr_n;
      end
   end

endmodule

// File: rtl/alu8_flagcore_chk.sv
module alu8_flagcore_chk
   import alu8_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_valid,
   input logic [4:0]        op_code,
   input logic [WIDTH-1:0]  reg_i,
   input logic [WIDTH-1:0]  opnd_i,
   input logic [WIDTH-1:0]  result_q,
   input logic [SR_W-1:0]   status_q,
   input logic              res_vld_q
);

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(status_q) && $stable(result_q));

   // R12
   vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_writes_result(op_code)) |=> res_vld_q);

   // R12
   vld_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_valid && op_writes_result(op_code)) |=> !res_vld_q);

   // R2
   add_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_ADD_C) |=> status_q[5:2] == 4'b0);

   // R4
   cmp_keeps_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_CMP) |=> $stable(result_q) && status_q[5:2] == 4'b0);

   // R5
   logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_AND) |=>
         status_q[C_BIT] == $past(status_q[C_BIT]) && status_q[V_BIT] == $past(status_q[V_BIT]));

   // R6
   inc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_INC) |=> result_q == WIDTH'($past(reg_i) + 1'b1));

   // R9
   test_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_TEST) |=>
         status_q[N_BIT] == $past(opnd_i[WIDTH-1]) && status_q[V_BIT] == $past(opnd_i[WIDTH-2]) &&
         status_q[C_BIT] == $past(status_q[C_BIT]) && $stable(result_q));

   // R10
   setc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_SETC) |=> status_q[C_BIT]);

   // R10
   clrv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_code == OP_CLRV) |=> !status_q[V_BIT] && $stable(result_q));

endmodule

bind alu8_flagcore alu8_flagcore_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu8_flagcore_tb.sv
module alu8_flagcore_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid = 1'b0;
   logic [4:0] op_code = '0;
   logic [7:0] reg_i = '0;
   logic [7:0] opnd_i = '0;
   logic [7:0] result_q;
   logic [7:0] status_q;
   logic       res_vld_q;

   int vectors = 0;
   int miscompares = 0;
   int m_st = 0;
   int m_res = 0;
   int m_vld = 0;
   string tag = "R1";
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   alu8_flagcore u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .reg_i     (reg_i),
      .opnd_i    (opnd_i),
      .result_q  (result_q),
      .status_q  (status_q),
      .res_vld_q (res_vld_q)
   );

   function automatic int nz(int r);
      return ((r == 0) ? 2 : 0) | (r & 128);
   endfunction

   task automatic check();
      vectors++;
      if (status_q !== m_st[7:0] || result_q !== m_res[7:0] || res_vld_q !== m_vld[0]) begin
         miscompares++;
         $display("FAIL %s: status=%02h result=%02h vld=%0b expected status=%02h result=%02h vld=%0b",
                  tag, status_q, result_q, res_vld_q, m_st[7:0], m_res[7:0], m_vld[0]);
      end
   endtask

   // reference model: state after the next rising edge
   task automatic model(input bit v, input int op, input int a, input int b);
      int c, t, r, bi;
      c = m_st & 1;
      m_vld = 0;
      if (!v) begin
         tag = "R11";
         return;
      end
      case (op)
         0, 1, 2: begin
            bi = (op == 0) ? b : (b ^ 255);
            t  = a + bi + ((op == 2) ? 1 : c);
            r  = t & 255;
            m_st = nz(r) | ((t >= 256) ? 1 : 0) | ((((a ^ r) & (bi ^ r) & 128) != 0) ? 64 : 0);
            if (op != 2) begin m_res = r; m_vld = 1; end
            tag = (op == 0) ? "R2" : (op == 1) ? "R3" : "R4";
         end
         3, 4, 5, 13: begin
            r = (op == 3) ? (a & b) : (op == 4) ? (a | b) : (op == 5) ? (a ^ b) : b;
            m_st = (m_st & ~8'h82) | nz(r);
            m_res = r; m_vld = 1; tag = "R5";
         end
         6, 8: begin
            r = ((a << 1) & 255) | ((op == 8) ? c : 0);
            m_st = (m_st & ~8'h83) | nz(r) | ((a >> 7) & 1);
            m_res = r; m_vld = 1; tag = "R7";
         end
         7, 9: begin
            r = (a >> 1) | ((op == 9) ? (c << 7) : 0);
            m_st = (m_st & ~8'h83) | nz(r) | (a & 1);
            m_res = r; m_vld = 1; tag = "R8";
         end
         10, 11: begin
            r = (op == 10) ? ((a + 1) % 256) : ((a + 255) % 256);
            m_st = (m_st & ~8'h82) | nz(r);
            m_res = r; m_vld = 1; tag = "R6";
         end
         12: begin
            m_st = (m_st & 8'h3D) | (b & 8'hC0) | (((a & b) == 0) ? 2 : 0);
            tag = "R9";
         end
         16: begin m_st = m_st | 1;        tag = "R10"; end
         17: begin m_st = m_st & ~1;       tag = "R10"; end
         18: begin m_st = m_st & ~64;      tag = "R10"; end
         19: begin m_st = b;               tag = "R10"; end
         default: tag = "R11";
      endcase
      if (m_vld == 1) tag = {tag, "/R12"};
   endtask

   task automatic step(input bit v, input int op, input int a, input int b);
      @(negedge clk);
      check();
      op_valid = v;
      op_code  = op[4:0];
      reg_i    = a[7:0];
      opnd_i   = b[7:0];
      model(v, op, a, b);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      // R1: reset state, checked while reset is held and on release
      repeat (3) @(negedge clk);
      tag = "R1";
      check();
      rst_n = 1'b1;
      step(1'b0, 0, 0, 0);
      // R2: signed overflow into negative, then carry out with carry in
      step(1'b1, 0, 8'h50, 8'h50);
      step(1'b1, 19, 0, 8'hFF);
      step(1'b1, 0, 8'hFF, 8'h01);
      // R3: borrow cases
      step(1'b1, 1, 8'h00, 8'h01);
      step(1'b1, 16, 0, 0);
      step(1'b1, 1, 8'h80, 8'h01);
      // R4: compare equal, less, greater
      step(1'b1, 19, 0, 8'hFF);
      step(1'b1, 2, 8'h40, 8'h40);
      step(1'b1, 2, 8'h10, 8'h20);
      step(1'b1, 2, 8'h20, 8'h10);
      // R5 with all status bits preset
      step(1'b1, 19, 0, 8'hFF);
      step(1'b1, 3, 8'hF0, 8'h0F);
      step(1'b1, 4, 8'h80, 8'h01);
      step(1'b1, 5, 8'hAA, 8'hAA);
      step(1'b1, 13, 8'h00, 8'h7F);
      // R6 wrap
      step(1'b1, 10, 8'hFF, 0);
      step(1'b1, 11, 8'h00, 0);
      step(1'b1, 10, 8'h7F, 0);
      // R7 / R8 with carry set and clear
      step(1'b1, 16, 0, 0);
      step(1'b1, 8, 8'h80, 0);
      step(1'b1, 6, 8'h81, 0);
      step(1'b1, 9, 8'h01, 0);
      step(1'b1, 9, 8'h00, 0);
      step(1'b1, 7, 8'h01, 0);
      // R9
      step(1'b1, 16, 0, 0);
      step(1'b1, 12, 8'h0F, 8'hC0);
      step(1'b1, 12, 8'hFF, 8'h01);
      // R10
      step(1'b1, 17, 0, 0);
      step(1'b1, 18, 0, 0);
      step(1'b1, 19, 0, 8'h5A);
      // R11: idle and unassigned codes
      step(1'b0, 0, 8'hFF, 8'hFF);
      step(1'b1, 14, 8'h12, 8'h34);
      step(1'b1, 31, 8'h12, 8'h34);
      // random traffic over all codes
      for (int i = 0; i < 4000; i++) begin
         step(($urandom_range(0, 9) < 8), int'($urandom_range(0, 31)),
              int'($urandom_range(0, 255)), int'($urandom_range(0, 255)));
      end
      step(1'b0, 0, 0, 0);
      step(1'b0, 0, 0, 0);
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule